// File: doc/BRIEF.md
# System Call Request and Protection Mode Controller

This block holds three software-visible registers: a system-call request register, a system-call argument register, and the device protection-mode register. Writing the request flag raises a non-maskable interrupt toward the CPU. The interrupt stays up until the service routine clears the flag. The block records whether the CPU or the debug port placed the request. It only lets the privileged-mode bit be set by CPU code that is running with ROM execution enabled. It also keeps the protection mode behind a lock that can be set once and never cleared.

A simple register port drives the block: a write strobe, a word index, write data and a master-ID bit. Read data comes back combinationally for the word index that is presented. A status input reports whether the CPU is executing from ROM, and a one-cycle pulse marks the fetch of the system-call interrupt vector from boot ROM. The outputs are the NMI, the privileged bit, a decoded protection state, and a flag that tells the CPU address path to steer accesses to the reset vector (addresses 0x0 to 0x7) into ROM. The debug port's path never uses this flag.

The reset input is asserted asynchronously. Its release is synchronised to the clock inside the block.

Top module: `sysc_prot_ctrl`

## Requirements
- R1: Writing the request register with bit 31 set makes `sys_nmi` high from the next clock edge. `sys_nmi` stays high until a request-register write with bit 31 clear.
- R2: Request-register bit 27 (read-only) records the writer: 0 for CPU, 1 for debug port. It is updated on a request-register write only when bit 31 was 0 before that write, and it holds otherwise.
- R3: The privileged bit (request-register bit 25, also output `priv_mode`) becomes 1 only on a CPU write with bit 25 set while the ROM-enable flag is 1. Any other request-register write loads 0. Writes to other registers leave it unchanged.
- R4: The ROM-enable flag (request-register bit 26, read-only) is 1 after reset. It is set in any cycle with `nmi_vec_fetch` high, and a fetch takes precedence over a clear. It is cleared in a cycle with `cpu_in_rom` low and no fetch.
- R5: Request-register bit 24 disables reset-vector redirection. It resets to 0, and `vec_redirect` is its inverse.
- R6: Protection register bits [3:0] decode with priority to `prot_state`. 1xxx gives BOOT (4), 01xx gives KILL (3), 001x gives PROTECTED (2), 0001 gives OPEN (1), and 0000 gives VIRGIN (0).
- R7: Mode 0000 with the flash-lock bit (protection register bit 8) set decodes as DEAD (5). For any other mode, flash-lock has no effect on `prot_state`.
- R8: Protection register bit 15 is the lock. Once it is 1 it stays 1 until reset. While it is 1, writes leave the mode and flash-lock fields unchanged. A write that sets the lock from 0 also loads the mode and flash-lock fields.
- R9: The opcode field (request register bits [15:0]) and the 32-bit argument register (word 1) read back exactly as written.
- R10: After reset every field reads 0 except the ROM-enable flag. Word index 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index: 0 request, 1 argument, 2 protection |
| reg_wdata | input | DATA_W | Write data |
| reg_master | input | 1 | Writer identity: 0 CPU, 1 debug port |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| cpu_in_rom | input | 1 | CPU is currently executing from ROM |
| nmi_vec_fetch | input | 1 | Pulse: system-call NMI vector fetched from boot ROM |
| sys_nmi | output | 1 | Non-maskable interrupt request |
| priv_mode | output | 1 | Privileged-mode bit |
| prot_state | output | 3 | Decoded protection state (0 VIRGIN .. 5 DEAD) |
| vec_redirect | output | 1 | Redirect CPU reset-vector accesses to ROM |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume that `reg_master` and `reg_wdata` are meaningful only in cycles where `reg_wr` is high. The bench meets this by changing every input on the falling edge and holding the write strobe for exactly one rising edge. The bench keeps `cpu_in_rom` high except in the scenarios that deliberately clear the ROM-enable flag. It raises `nmi_vec_fetch` only as a single-cycle pulse, so the set and clear rules of the flag are exercised one at a time and also together.

// File: rtl/sysc_pkg.sv
package sysc_pkg;

  typedef enum logic [2:0] {
    PS_VIRGIN = 3'd0,
    PS_OPEN   = 3'd1,
    PS_PROT   = 3'd2,
    PS_KILL   = 3'd3,
    PS_BOOT   = 3'd4,
    PS_DEAD   = 3'd5
  } prot_state_e;

  localparam int MODE_W = 4;

  // word indices
  localparam int IDX_REQ  = 0;
  localparam int IDX_ARG  = 1;
  localparam int IDX_PROT = 2;

  // request register fields
  localparam int REQ_REDIR_BIT = 24;
  localparam int REQ_PRIV_BIT  = 25;
  localparam int REQ_ROMEN_BIT = 26;
  localparam int REQ_SRC_BIT   = 27;
  localparam int REQ_GO_BIT    = 31;

  // protection register fields
  localparam int PROT_FLOCK_BIT = 8;
  localparam int PROT_LOCK_BIT  = 15;

endpackage

// File: rtl/sysc_rst_sync.sv
module sysc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/sysc_req_reg.sv
module sysc_req_reg #(
  parameter int OPC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_master,
  input  logic [OPC_W-1:0] wr_opc,
  input  logic             wr_redir,
  input  logic             wr_priv,
  input  logic             wr_go,
  input  logic             cpu_in_rom,
  input  logic             vec_fetch,
  output logic [OPC_W-1:0] opc_q,
  output logic             redir_dis_q,
  output logic             priv_q,
  output logic             rom_en_q,
  output logic             src_q,
  output logic             go_q
);

  logic [OPC_W-1:0] opc_d;
  logic             redir_d;
  logic             priv_d;
  logic             rom_d;
  logic             src_d;
  logic             src_en;
  logic             go_d;

  // next-state
  always_comb begin
    opc_d   = wr_opc;
    redir_d = wr_redir;
    go_d    = wr_go;
    priv_d  = wr_priv & ~wr_master & rom_en_q;
    src_d   = wr_master;
    src_en  = wr_en & ~go_q;
    if (vec_fetch)       rom_d = 1'b1;
    else if (!cpu_in_rom) rom_d = 1'b0;
    else                 rom_d = rom_en_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q       <= '0;
      redir_dis_q <= 1'b0;
      priv_q      <= 1'b0;
      go_q        <= 1'b0;
    end else if (wr_en) begin
      opc_q       <= opc_d;
      redir_dis_q <= redir_d;
      priv_q      <= priv_d;
      go_q        <= go_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= 1'b0;
    else if (src_en) src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rom_en_q <= 1'b1;
    else        rom_en_q <= rom_d;
  end

endmodule

// File: rtl/sysc_arg_reg.sv
module sysc_arg_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] arg_q
);

  logic [DATA_W-1:0] arg_d;

  always_comb begin
    arg_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arg_q <= '0;
    else if (wr_en) arg_q <= arg_d;
  end

endmodule

// File: rtl/sysc_prot_reg.sv
module sysc_prot_reg
  import sysc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              wr_flock,
  input  logic              wr_lock,
  output logic [MODE_W-1:0] mode_q,
  output logic              flock_q,
  output logic              lock_q,
  output prot_state_e       state
);

  logic [MODE_W-1:0] mode_d;
  logic              flock_d;
  logic              lock_d;
  logic              fld_en;

  // next-state: fields load only while unlocked, lock only accumulates
  always_comb begin
    fld_en  = wr_en & ~lock_q;
    mode_d  = wr_mode;
    flock_d = wr_flock;
    lock_d  = lock_q | (wr_en & wr_lock);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      flock_q <= 1'b0;
    end else if (fld_en) begin
      mode_q  <= mode_d;
      flock_q <= flock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // priority decode, highest set bit wins
  always_comb begin
    casez (mode_q)
      4'b1???: state = PS_BOOT;
      4'b01??: state = PS_KILL;
      4'b001?: state = PS_PROT;
      4'b0001: state = PS_OPEN;
      default: state = flock_q ? PS_DEAD : PS_VIRGIN;
    endcase
  end

endmodule

// File: rtl/sysc_prot_ctrl.sv
module sysc_prot_ctrl
  import sysc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 32,
  parameter int OPC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_master,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_in_rom,
  input  logic              nmi_vec_fetch,
  output logic              sys_nmi,
  output logic              priv_mode,
  output logic [2:0]        prot_state,
  output logic              vec_redirect
);

  localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(IDX_REQ);
  localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(IDX_ARG);
  localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(IDX_PROT);

  logic              rst_core_n;
  logic              wr_req, wr_arg, wr_prot;

  logic [OPC_W-1:0]  opc_q;
  logic              redir_dis_q, priv_q, rom_en, src_q, req_q;
  logic [DATA_W-1:0] arg_q;
  logic [MODE_W-1:0] mode_q;
  logic              flash_lock_q, lock_q;
  prot_state_e       state;

  logic [DATA_W-1:0] rd_req, rd_prot;

  sysc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // write decode
  always_comb begin
    wr_req  = reg_wr && (reg_addr == A_REQ);
    wr_arg  = reg_wr && (reg_addr == A_ARG);
    wr_prot = reg_wr && (reg_addr == A_PROT);
  end

  sysc_req_reg #(.OPC_W(OPC_W)) u_req (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_req),
    .wr_master   (reg_master),
    .wr_opc      (reg_wdata[OPC_W-1:0]),
    .wr_redir    (reg_wdata[REQ_REDIR_BIT]),
    .wr_priv     (reg_wdata[REQ_PRIV_BIT]),
    .wr_go       (reg_wdata[REQ_GO_BIT]),
    .cpu_in_rom  (cpu_in_rom),
    .vec_fetch   (nmi_vec_fetch),
    .opc_q       (opc_q),
    .redir_dis_q (redir_dis_q),
    .priv_q      (priv_q),
    .rom_en_q    (rom_en),
    .src_q       (src_q),
    .go_q        (req_q)
  );

  sysc_arg_reg #(.DATA_W(DATA_W)) u_arg (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_arg),
    .wr_data (reg_wdata),
    .arg_q   (arg_q)
  );

  sysc_prot_reg u_prot (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_prot),
    .wr_mode  (reg_wdata[MODE_W-1:0]),
    .wr_flock (reg_wdata[PROT_FLOCK_BIT]),
    .wr_lock  (reg_wdata[PROT_LOCK_BIT]),
    .mode_q   (mode_q),
    .flock_q  (flash_lock_q),
    .lock_q   (lock_q),
    .state    (state)
  );

  // read assembly
  always_comb begin
    rd_req                 = '0;
    rd_req[OPC_W-1:0]      = opc_q;
    rd_req[REQ_REDIR_BIT]  = redir_dis_q;
    rd_req[REQ_PRIV_BIT]   = priv_q;
    rd_req[REQ_ROMEN_BIT]  = rom_en;
    rd_req[REQ_SRC_BIT]    = src_q;
    rd_req[REQ_GO_BIT]     = req_q;

    rd_prot                 = '0;
    rd_prot[MODE_W-1:0]     = mode_q;
    rd_prot[PROT_FLOCK_BIT] = flash_lock_q;
    rd_prot[PROT_LOCK_BIT]  = lock_q;

    unique case (reg_addr)
      A_REQ:   reg_rdata = rd_req;
      A_ARG:   reg_rdata = arg_q;
      A_PROT:  reg_rdata = rd_prot;
      default: reg_rdata = '0;
    endcase
  end

  assign sys_nmi      = req_q;
  assign priv_mode    = priv_q;
  assign prot_state   = state;
  assign vec_redirect = ~redir_dis_q;

endmodule

// File: rtl/sysc_prot_ctrl_chk.sv
module sysc_prot_ctrl_chk
  import sysc_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wr_go,
  input logic              reg_master,
  input logic              cpu_in_rom,
  input logic              nmi_vec_fetch,
  input logic              sys_nmi,
  input logic              priv_mode,
  input logic              rom_en,
  input logic              src_q,
  input logic              req_q,
  input logic [MODE_W-1:0] mode_q,
  input logic              flash_lock_q,
  input logic              lock_q,
  input logic [2:0]        prot_state
);

  logic req_write;
  assign req_write = reg_wr && (reg_addr == ADDR_W'(IDX_REQ));

  AST_NMI_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && wr_go) |=> sys_nmi); // R1

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_nmi && !req_write) |=> sys_nmi); // R1

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> $stable(src_q)); // R2

  AST_PRIV_SET_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(priv_mode) |-> $past(req_write && !reg_master && rom_en)); // R3

  AST_ROMEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_vec_fetch |=> rom_en); // R4

  AST_ROMEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_in_rom && !nmi_vec_fetch) |=> !rom_en); // R4

  AST_DEAD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == '0 && flash_lock_q) |-> (prot_state == 3'(PS_DEAD))); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(mode_q) && $stable(flash_lock_q))); // R8

endmodule

bind sysc_prot_ctrl sysc_prot_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .wr_go         (reg_wdata[sysc_pkg::REQ_GO_BIT]),
  .reg_master    (reg_master),
  .cpu_in_rom    (cpu_in_rom),
  .nmi_vec_fetch (nmi_vec_fetch),
  .sys_nmi       (sys_nmi),
  .priv_mode     (priv_mode),
  .rom_en        (rom_en),
  .src_q         (src_q),
  .req_q         (req_q),
  .mode_q        (mode_q),
  .flash_lock_q  (flash_lock_q),
  .lock_q        (lock_q),
  .prot_state    (prot_state)
);

// File: tb/sysc_prot_ctrl_bench.sv
module sysc_prot_ctrl_bench;

  localparam logic [1:0] W_REQ  = 2'd0;
  localparam logic [1:0] W_ARG  = 2'd1;
  localparam logic [1:0] W_PROT = 2'd2;
  localparam logic [1:0] W_NONE = 2'd3;
  localparam logic CPU = 1'b0;
  localparam logic DBG = 1'b1;

  localparam logic [31:0] B_REDIR = 32'h0100_0000;
  localparam logic [31:0] B_PRIV  = 32'h0200_0000;
  localparam logic [31:0] B_ROMEN = 32'h0400_0000;
  localparam logic [31:0] B_SRC   = 32'h0800_0000;
  localparam logic [31:0] B_GO    = 32'h8000_0000;
  localparam logic [31:0] B_FLOCK = 32'h0000_0100;
  localparam logic [31:0] B_LOCK  = 32'h0000_8000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_master;
  logic [31:0] reg_rdata;
  logic        cpu_in_rom;
  logic        nmi_vec_fetch;
  logic        sys_nmi;
  logic        priv_mode;
  logic [2:0]  prot_state;
  logic        vec_redirect;

  int checks;
  int fails;
  bit done;

  sysc_prot_ctrl u_sysc_prot_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_master    (reg_master),
    .reg_rdata     (reg_rdata),
    .cpu_in_rom    (cpu_in_rom),
    .nmi_vec_fetch (nmi_vec_fetch),
    .sys_nmi       (sys_nmi),
    .priv_mode     (priv_mode),
    .prot_state    (prot_state),
    .vec_redirect  (vec_redirect)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic m);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_master = m;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_master = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(W_REQ, v);  check("R10 request reg after reset", v, B_ROMEN);
    rd(W_ARG, v);  check("R10 argument reg after reset", v, 32'h0);
    rd(W_PROT, v); check("R10 protection reg after reset", v, 32'h0);
    check("R10 nmi after reset", {31'h0, sys_nmi}, 32'h0);
    check("R10 priv after reset", {31'h0, priv_mode}, 32'h0);
    check("R5 redirect after reset", {31'h0, vec_redirect}, 32'h1);
    check("R6 VIRGIN after reset", {29'h0, prot_state}, 32'd0);
  endtask

  task automatic t_args;
    logic [31:0] v;
    wr(W_ARG, 32'hA5C3_0F96, CPU);
    rd(W_ARG, v); check("R9 argument readback", v, 32'hA5C3_0F96);
    wr(W_REQ, 32'h0000_BEEF, CPU);
    rd(W_REQ, v); check("R9 opcode readback", v, B_ROMEN | 32'h0000_BEEF);
    wr(W_NONE, 32'hFFFF_FFFF, DBG);
    rd(W_NONE, v); check("R10 unused index reads zero", v, 32'h0);
    rd(W_ARG, v);  check("R10 unused write leaves argument", v, 32'hA5C3_0F96);
    rd(W_REQ, v);  check("R10 unused write leaves request", v, B_ROMEN | 32'h0000_BEEF);
    check("R10 unused write leaves nmi", {31'h0, sys_nmi}, 32'h0);
  endtask

  task automatic t_redirect;
    wr(W_REQ, B_REDIR, CPU);
    check("R5 redirect disabled", {31'h0, vec_redirect}, 32'h0);
    wr(W_REQ, 32'h0, CPU);
    check("R5 redirect re-enabled", {31'h0, vec_redirect}, 32'h1);
  endtask

  task automatic t_nmi_source;
    logic [31:0] v;
    wr(W_REQ, B_GO | 32'h0000_1234, DBG);
    check("R1 nmi after request", {31'h0, sys_nmi}, 32'h1);
    rd(W_REQ, v); check("R2 debug source captured", v, B_GO | B_SRC | B_ROMEN | 32'h1234);
    @(negedge clk);
    check("R1 nmi held", {31'h0, sys_nmi}, 32'h1);
    wr(W_REQ, B_GO | 32'h0000_5678, CPU);
    rd(W_REQ, v); check("R2 source held while pending", v, B_GO | B_SRC | B_ROMEN | 32'h5678);
    wr(W_REQ, 32'h0, CPU);
    check("R1 nmi cleared by handler", {31'h0, sys_nmi}, 32'h0);
    rd(W_REQ, v); check("R2 source held on clearing write", v & B_SRC, B_SRC);
    wr(W_REQ, 32'h0, CPU);
    rd(W_REQ, v); check("R2 cpu source captured", v & B_SRC, 32'h0);
  endtask

  task automatic t_priv;
    wr(W_REQ, B_PRIV, CPU);
    check("R3 cpu sets priv with rom enabled", {31'h0, priv_mode}, 32'h1);
    wr(W_ARG, 32'hFFFF_FFFF, CPU);
    check("R3 other register write keeps priv", {31'h0, priv_mode}, 32'h1);
    wr(W_REQ, B_PRIV, DBG);
    check("R3 debug write forces priv 0", {31'h0, priv_mode}, 32'h0);
    wr(W_REQ, B_PRIV, CPU);
    wr(W_REQ, 32'h0, CPU);
    check("R3 cpu write of 0 clears priv", {31'h0, priv_mode}, 32'h0);
  endtask

  task automatic t_romen;
    logic [31:0] v;
    @(negedge clk); cpu_in_rom = 1'b0;
    @(negedge clk); cpu_in_rom = 1'b1;
    rd(W_REQ, v); check("R4 rom enable cleared outside rom", v & B_ROMEN, 32'h0);
    wr(W_REQ, B_PRIV, CPU);
    check("R3 priv refused with rom disabled", {31'h0, priv_mode}, 32'h0);
    @(negedge clk); cpu_in_rom = 1'b0; nmi_vec_fetch = 1'b1;
    @(negedge clk); cpu_in_rom = 1'b1; nmi_vec_fetch = 1'b0;
    rd(W_REQ, v); check("R4 vector fetch sets rom enable", v & B_ROMEN, B_ROMEN);
    wr(W_REQ, B_PRIV, CPU);
    check("R3 priv allowed after vector fetch", {31'h0, priv_mode}, 32'h1);
  endtask

  task automatic t_decode;
    logic [3:0] modes [8] = '{4'b1000, 4'b1111, 4'b0100, 4'b0110,
                              4'b0010, 4'b0011, 4'b0001, 4'b0000};
    logic [2:0] exps  [8] = '{3'd4, 3'd4, 3'd3, 3'd3, 3'd2, 3'd2, 3'd1, 3'd0};
    for (int i = 0; i < 8; i++) begin
      wr(W_PROT, {28'h0, modes[i]}, CPU);
      check($sformatf("R6 decode of mode %b", modes[i]), {29'h0, prot_state}, {29'h0, exps[i]});
    end
  endtask

  task automatic t_dead;
    wr(W_PROT, B_FLOCK, CPU);
    check("R7 virgin with flash lock is DEAD", {29'h0, prot_state}, 32'd5);
    wr(W_PROT, B_FLOCK | 32'h1, CPU);
    check("R7 flash lock ignored for OPEN", {29'h0, prot_state}, 32'd1);
  endtask

  task automatic t_lock;
    logic [31:0] v;
    wr(W_PROT, B_LOCK | 32'h2, CPU);
    rd(W_PROT, v); check("R8 lock write loads mode", v, B_LOCK | 32'h2);
    check("R8 state after locking", {29'h0, prot_state}, 32'd2);
    wr(W_PROT, 32'h8, DBG);
    rd(W_PROT, v); check("R8 locked mode ignores write", v, B_LOCK | 32'h2);
    check("R8 state unchanged under lock", {29'h0, prot_state}, 32'd2);
    wr(W_PROT, B_FLOCK, CPU);
    rd(W_PROT, v); check("R8 locked flash-lock ignores write", v, B_LOCK | 32'h2);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_master = 1'b0;
    cpu_in_rom = 1'b1; nmi_vec_fetch = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_args();
    t_redirect();
    t_nmi_source();
    t_priv();
    t_romen();
    t_decode();
    t_dead();
    t_lock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule